// File: doc/BRIEF.md
# Light-Grid Receiver Chain Control Cell

One receiver position in a daisy-chained light curtain needs a small piece of control logic that decides when its photo amplifier and its current-output stage draw power. This cell holds a three-stage token shift register: the first stages capture on the rising clock edge and the last stage captures on the falling edge. The last stage feeds the next cell, so a single 1 put into the first cell walks down the chain and wakes one receiver at a time.

The amplifier is switched on as soon as the serial input reads 1, so its front end has the time before the clock edge to settle. The output stage is switched on only while the first stage holds the token, for exactly one clock period. When the input is low at the next rising edge, the cell returns to standby. The token moves to the second stage at that edge and appears on the serial output half a cycle later. Because of that half-cycle offset, the next cell never samples a value that is changing at the same edge.

Top module: `lgc_chain_cell`

## Requirements
- R1: While rst_n is low at a rising edge (synchronous, active-low), all three stages clear at that edge and at the falling edge that follows. After reset, drv_en and ser_out are 0 and amp_en equals ser_in.
- R2: drv_en is 1 in the clock period after a rising edge at which ser_in was 1.
- R3: drv_en is 0 in the clock period after a rising edge at which ser_in was 0. The output stage is then off and the cell is in standby.
- R4: amp_en is 1 whenever ser_in is 1, without waiting for a clock edge, and whenever drv_en is 1. It is 0 when both are 0.
- R5: ser_out changes only at falling clock edges. After the falling edge that follows rising edge n, it equals the value ser_in had at rising edge n-1.
- R6: In a chain where each cell's ser_in is the previous cell's ser_out, a 1 sampled by cell 0 at rising edge n enables drv_en of cell k for the single period after rising edge n+2k.
- R7: When a single 1 is injected into a chain, at most one cell has drv_en high in any clock period. After reset, no cell has it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chain clock. The first stages use its rising edge and the last stage uses its falling edge. |
| rst_n | input | 1 | Power-down reset, active low, sampled on both clock edges |
| ser_in | input | 1 | Token input from the previous cell or from the controller |
| amp_en | output | 1 | Photo amplifier power enable |
| drv_en | output | 1 | Current-output stage enable (high = driving, low = high impedance) |
| ser_out | output | 1 | Token output to the next cell |

## Verification
Four cells are chained and driven with a lone token, a run of back-to-back 1s, an alternating 1/0 pattern, and a token cut off by a reset in mid-flight. The lone token tests the one-period output window and the two-cycle hop per cell. Back-to-back 1s show that adjacent cells stay separate, with no merging and no lost bit. The alternating pattern tests that the falling-edge stage meets the next cell's rising-edge capture without a race. The mid-flight reset shows that reset clears the falling-edge stage as well as the rising-edge stages. The amplifier enable is also sampled just after the input changes, before any clock edge.

// File: rtl/lgc_pkg.sv
// Shared constants for the light-grid chain control cell.
// Assumes a single clock domain; both clock edges are used.
package lgc_pkg;
    // Number of stages that capture on the rising clock edge.
    localparam int unsigned LGC_RISE_DEPTH = 2;
    // Index of the stage that owns the output-stage enable.
    localparam int unsigned LGC_DRV_STAGE  = 0;

    // Decoded power request of one cell.
    typedef struct packed {
        logic amp;
        logic drv;
    } lgc_power_t;
endpackage

// File: rtl/lgc_rise_stages.sv
// Rising-edge part of the token shift register.
// Stage 0 samples ser_in. Each later stage samples the one before it.
// Assumes that rst_n is synchronous and active low.
module lgc_rise_stages #(
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d_in,
    output logic [DEPTH-1:0] q
);
    localparam int unsigned LAST = DEPTH - 1;

    // Stage 0: capture the serial input on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q[0] <= 1'b0;
        else        q[0] <= d_in;
    end

    genvar g;
    generate
        for (g = 1; g <= LAST; g++) begin : g_stage
            // Later stages: shift the token one stage on.
            always_ff @(posedge clk) begin
                if (!rst_n) q[g] <= 1'b0;
                else        q[g] <= q[g-1];
            end
        end
    endgenerate
endmodule

// File: rtl/lgc_fall_stage.sv
// Last stage of the token shift register, which captures on the falling edge.
// The half-cycle offset keeps the next cell's rising-edge capture away from
// the moment this output changes. Reset is sampled at the falling edge too.
module lgc_fall_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q
);
    // Capture the final rising-edge stage half a cycle later.
    always_ff @(negedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d_in;
    end
endmodule

// File: rtl/lgc_power_decode.sv
// Turns the serial input and the first stage into the two power enables.
// Purely combinational. Assumes the first stage is the token holder.
module lgc_power_decode
    import lgc_pkg::*;
(
    input  logic       ser_in,
    input  logic       lead_stage,
    output lgc_power_t pwr
);
    // Amplifier wakes on input data; output stage follows the token holder.
    always_comb begin
        pwr.drv = lead_stage;
        pwr.amp = ser_in | lead_stage;
    end
endmodule

// File: rtl/lgc_chain_cell.sv
// Control cell for one receiver of a daisy-chained light curtain.
// Holds a token shift register: lgc_pkg::LGC_RISE_DEPTH rising-edge stages
// followed by one falling-edge stage. From the stages it decodes the power
// enables for the amplifier and the current-output stage.
// Assumes that rst_n is synchronous and active low.
module lgc_chain_cell
    import lgc_pkg::*;
#(
    parameter int unsigned RISE_DEPTH = LGC_RISE_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic amp_en,
    output logic drv_en,
    output logic ser_out
);
    localparam int unsigned LAST_RISE = RISE_DEPTH - 1;

    logic [RISE_DEPTH-1:0] rise_q;
    logic                  tail_q;
    lgc_power_t            pwr;

    lgc_rise_stages #(.DEPTH(RISE_DEPTH)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (ser_in),
        .q     (rise_q)
    );

    lgc_fall_stage u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rise_q[LAST_RISE]),
        .q     (tail_q)
    );

    lgc_power_decode u_dec (
        .ser_in     (ser_in),
        .lead_stage (rise_q[LGC_DRV_STAGE]),
        .pwr        (pwr)
    );

    // Drive the ports from the decoded enables and the falling-edge stage.
    always_comb begin
        amp_en  = pwr.amp;
        drv_en  = pwr.drv;
        ser_out = tail_q;
    end
endmodule

// File: rtl/lgc_chain_cell_chk.sv
// Assertion checker for lgc_chain_cell. It is attached by the bind below.
module lgc_chain_cell_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_in,
    input logic amp_en,
    input logic drv_en,
    input logic ser_out
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> !drv_en); // R1
    AST_DRV_TAKES_TOKEN: assert property (@(posedge clk) disable iff (!rst_n) ser_in |=> drv_en); // R2
    AST_DRV_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) !ser_in |=> !drv_en); // R3
    AST_AMP_ON_INPUT: assert property (@(posedge clk) disable iff (!rst_n) ser_in |-> amp_en); // R4
    AST_AMP_COVERS_DRV: assert property (@(posedge clk) disable iff (!rst_n) drv_en |-> amp_en); // R4
    AST_TAIL_FOLLOWS_ONE: assert property (@(negedge clk) disable iff (!rst_n) drv_en |-> ##2 ser_out); // R5
    AST_TAIL_FOLLOWS_ZERO: assert property (@(negedge clk) disable iff (!rst_n) !drv_en |-> ##2 !ser_out); // R5
endmodule

bind lgc_chain_cell lgc_chain_cell_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_in  (ser_in),
    .amp_en  (amp_en),
    .drv_en  (drv_en),
    .ser_out (ser_out)
);

// File: tb/lgc_chain_cell_bench.sv
// Chains four cells and compares every output with a history-based model
// on every clock.
module lgc_chain_cell_bench;
    localparam int CLK_PERIOD = 20;
    localparam int CELLS      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic [CELLS-1:0] amp_en, drv_en, ser_out;
    logic [CELLS:0]   chain;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit primed = 0;
    bit h[$];   // h[j] = token value sampled by cell 0 at rising edge n-j

    always #(CLK_PERIOD/2) clk = ~clk;

    assign chain[0] = din;

    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        if (k == 0) begin : g_dut
            lgc_chain_cell u_lgc_chain_cell (
                .clk(clk), .rst_n(rst_n), .ser_in(chain[k]),
                .amp_en(amp_en[k]), .drv_en(drv_en[k]), .ser_out(chain[k+1]));
        end else begin : g_more
            lgc_chain_cell u_cell (
                .clk(clk), .rst_n(rst_n), .ser_in(chain[k]),
                .amp_en(amp_en[k]), .drv_en(drv_en[k]), .ser_out(chain[k+1]));
        end
    end
    assign ser_out = chain[CELLS:1];

    function automatic bit hb(int j);
        return (j >= 0 && j < h.size()) ? h[j] : 1'b0;
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Drive one cycle of stimulus, then check all cells after the falling edge.
    task automatic step(input logic r, input logic d, input bit single);
        rst_n = r;
        din = d;
        #1;
        if (primed && r) chk("R4", "amp_en[0] before edge", amp_en[0], d | hb(0));
        @(posedge clk);
        if (!r) begin
            h.delete();
        end else begin
            h.push_front(d);
            if (h.size() > 16) void'(h.pop_back());
        end
        primed = 1;
        #12;
        for (int k = 0; k < CELLS; k++) begin
            chk(r ? "R6" : "R1", $sformatf("drv_en[%0d]", k), drv_en[k], hb(2*k));
            chk(r ? "R5" : "R1", $sformatf("ser_out[%0d]", k), ser_out[k], hb(2*k+1));
            chk("R4", $sformatf("amp_en[%0d]", k), amp_en[k],
                ((k == 0) ? d : hb(2*k-1)) | hb(2*k));
        end
        if (single) begin
            checks++;
            if ($countones(drv_en) > 1) begin
                errors++;
                $display("FAIL R7 enabled cells actual=%b expected at most one", drv_en);
            end
        end
        #3;
    endtask

    initial begin
        @(posedge clk);
        #15;
        step(0, 0, 0);
        step(0, 1, 0);          // R1: reset wins over a token at the input
        step(0, 0, 0);
        step(1, 0, 1);
        chk("R7", "no cell enabled after reset", |drv_en, 1'b0);
        chk("R1", "no token left after reset", |ser_out, 1'b0);
        // Lone token walks the whole chain (R2, R3, R6, R7).
        step(1, 1, 1);
        for (int i = 0; i < 2*CELLS + 4; i++) step(1, 0, 1);
        // Back-to-back ones.
        for (int i = 0; i < 3; i++) step(1, 1, 0);
        for (int i = 0; i < 2*CELLS + 4; i++) step(1, 0, 0);
        // Alternating pattern.
        for (int i = 0; i < 8; i++) step(1, (i % 2) == 0, 0);
        for (int i = 0; i < 2*CELLS + 4; i++) step(1, 0, 0);
        // Token cut off by a reset in mid-flight.
        step(1, 1, 1);
        for (int i = 0; i < 3; i++) step(1, 0, 1);
        step(0, 0, 1);
        for (int i = 0; i < 2*CELLS + 2; i++) step(1, 0, 1);
        // A fresh lone token after the reset.
        step(1, 1, 1);
        for (int i = 0; i < 2*CELLS + 4; i++) step(1, 0, 1);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule